// File: doc/BRIEF.md
# DES Block Cipher Register Front-End

This block is the bus-facing shell around a DES / Triple-DES round engine. Software, or a DMA channel, reaches it through a 32-bit register window. Through that window it loads up to three 64-bit key slots, a 64-bit chaining value and the mode bits. It then streams 64-bit blocks through a two-word data window. The front-end hands each block to an external cipher engine with a one-cycle start pulse and waits for a done pulse. It captures the result and offers it back through the same window. The round logic itself sits outside this block.

Block flow is controlled by a four-state machine with the states `ST_IDLE`, `ST_LAUNCH`, `ST_WAIT` and `ST_HOLD`.
- `ST_IDLE` means input-ready. A write to the low data word moves the machine to `ST_LAUNCH`.
- `ST_LAUNCH` drives the engine start pulse for one cycle and always moves on to `ST_WAIT`.
- `ST_WAIT` moves to `ST_HOLD` when the engine reports done.
- `ST_HOLD` means output-ready. A read of the low data word moves the machine back to `ST_IDLE`.

Entering `ST_HOLD` raises the data-out event. Returning to `ST_IDLE` raises the data-in event. This gives interrupt-driven software a ping-pong rhythm. A byte-count register and a DMA mask register let a DMA engine run the same rhythm with level requests.

For CBC, the front-end does the chaining itself:
- On encryption it XORs the chaining value into the input, and the ciphertext becomes the new chaining value.
- On decryption it XORs the chaining value into the engine output, and the ciphertext that came in becomes the new chaining value.

Top module: `des_regfront`

## Requirements
- R1: After reset, control reads 0x2 (input-ready set), interrupt status reads 0x2, interrupt enable, length and DMA mask read 0, the interrupt output is low, and no DMA request is raised.
- R2: Key word k (0 to 5) lives at byte address 0x14 - 4*(k XOR 1) and reads back there. The engine key port carries word 0 in its top 32 bits down to word 5 in its bottom 32 bits. Slot 1 is words 0 and 1, slot 2 is words 2 and 3, slot 3 is words 4 and 5.
- R3: In control (0x20), bit 4 selects CBC, bit 3 selects Triple-DES and bit 2 selects encryption (1). These bits read back and drive the engine's tdes/encrypt inputs. Bit 1 (input-ready) and bit 0 (output-ready) are read-only.
- R4: While input-ready is set, a write to 0x2C launches a block. The high half is the last value written to 0x28 and the low half is the written 0x2C word. The engine start is asserted for exactly one cycle and input-ready clears.
- R5: Engine done sets output-ready. The result's high half reads at 0x28 and its low half at 0x2C. Reading 0x2C frees the buffer and sets input-ready again. Reading 0x28 alone leaves output-ready set.
- R6: Writes to 0x28/0x2C while input-ready is clear change neither the pending result nor output-ready.
- R7: In CBC encrypt mode, the engine input is the block XOR the chaining value, and the ciphertext becomes the chaining value. The chaining value reads at 0x18 (high half) and 0x1C (low half).
- R8: In CBC decrypt mode, the result is the engine output XOR the chaining value, and the incoming ciphertext becomes the chaining value.
- R9: In status (0x3C), bit 1 (data-in) sets when input-ready rises and bit 2 (data-out) sets when output-ready rises. Writing 0 to a bit clears it, writing 1 leaves it unchanged, and a hardware set wins over a clear in the same cycle.
- R10: The interrupt output is high exactly when a status bit and the same bit of enable (0x40) are both set.
- R11: Length (0x24) drops by 8 each time a result is freed by a read of 0x2C, and never goes below 0.
- R12: In the DMA mask (0x34), bit 5 enables input requests, bit 6 enables output requests and bit 7 is start. The input request is start, input enable, input-ready and length nonzero, all together. The output request is start, output enable, output-ready and length nonzero, all together.
- R13: Revision (0x30) returns the major version in bits 10:8 and the minor version in bits 5:0. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects only) |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| eng_start | output | 1 | One-cycle engine launch pulse |
| eng_din | output | 64 | Block presented to the engine |
| eng_key | output | 64*KEY_SLOTS | Key slots, word 0 at the top |
| eng_tdes | output | 1 | Triple-DES select |
| eng_encrypt | output | 1 | Encrypt (1) or decrypt (0) |
| eng_done | input | 1 | Engine completion pulse |
| eng_dout | input | 64 | Engine result, valid with eng_done |
| dma_in_req | output | 1 | Request for input words |
| dma_out_req | output | 1 | Request to drain output words |
| irq | output | 1 | Interrupt |

## Verification
The main block path is run through a keyed stand-in engine whose encrypt and decrypt are not the same function, so a swapped direction bit shows up as a wrong result.

Single-key ECB blocks in both directions pin the basic launch and capture path. A Triple-DES block tells apart a key that comes from one slot and a key that comes from all three. A two-block CBC encryption, followed by decryption of the same ciphertexts, recovers the plaintexts only if both chaining rules and the chaining-value update are right.

Writes made while a result is pending, and a read of only the high word, separate a correct release rule from an over-eager one. A three-block run with a byte count, and a DMA run, exercise the length countdown and the request gating.

// File: rtl/des_rf_pkg.sv
package des_rf_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_LAUNCH, ST_WAIT, ST_HOLD} flow_st_e;

    localparam int BLK_W  = 64;
    localparam int WORD_W = 32;

    localparam int OFS_IV_HI = 'h18;
    localparam int OFS_IV_LO = 'h1C;
    localparam int OFS_CTRL  = 'h20;
    localparam int OFS_LEN   = 'h24;
    localparam int OFS_D_HI  = 'h28;
    localparam int OFS_D_LO  = 'h2C;
    localparam int OFS_REV   = 'h30;
    localparam int OFS_DMA   = 'h34;
    localparam int OFS_STAT  = 'h3C;
    localparam int OFS_IEN   = 'h40;

    localparam int CTRL_CBC_B  = 4;
    localparam int CTRL_TDES_B = 3;
    localparam int CTRL_ENC_B  = 2;
    localparam int DMA_IN_B    = 5;
    localparam int DMA_OUT_B   = 6;
    localparam int DMA_GO_B    = 7;
    localparam int EV_IN_B     = 1;
    localparam int EV_OUT_B    = 2;
    localparam int BLK_BYTES   = BLK_W / 8;
endpackage

// File: rtl/des_rf_keystore.sv
module des_rf_keystore #(
    parameter int AW    = 8,
    parameter int WORDS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        addr,
    input  logic [31:0]          wdata,
    output logic [WORDS*32-1:0]  key_flat,
    output logic [31:0]          rd_word,
    output logic                 rd_hit
);
    localparam int TOP_OFS = 4 * WORDS - 4;

    logic [WORDS-1:0] hit;
    logic [31:0]      kword [WORDS];

    for (genvar k = 0; k < WORDS; k++) begin : g_slot
        localparam int SLOT_OFS = TOP_OFS - 4 * (k ^ 1);
        assign hit[k] = (addr == AW'(SLOT_OFS));
        always_ff @(posedge clk) begin
            if (!rst_n)
                kword[k] <= '0;
            else if (wr_en && hit[k])
                kword[k] <= wdata;
        end
        assign key_flat[(WORDS-1-k)*32 +: 32] = kword[k];
    end

    always_comb begin
        rd_word = '0;
        for (int k = 0; k < WORDS; k++)
            if (hit[k]) rd_word = kword[k];
    end

    assign rd_hit = |hit;
endmodule

// File: rtl/des_rf_seq.sv
module des_rf_seq
    import des_rf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic blk_wr,
    input  logic blk_rd,
    input  logic eng_done,
    output logic in_rdy,
    output logic out_rdy,
    output logic eng_start,
    output logic capture,
    output logic finish,
    output logic consume
);
    flow_st_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (blk_wr)   st_d = ST_LAUNCH;
            ST_LAUNCH:               st_d = ST_WAIT;
            ST_WAIT:   if (eng_done) st_d = ST_HOLD;
            ST_HOLD:   if (blk_rd)   st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        in_rdy    = (st_q == ST_IDLE);
        out_rdy   = (st_q == ST_HOLD);
        eng_start = (st_q == ST_LAUNCH);
        capture   = in_rdy && blk_wr;
        finish    = (st_q == ST_WAIT) && eng_done;
        consume   = out_rdy && blk_rd;
    end
endmodule

// File: rtl/des_rf_irq.sv
module des_rf_irq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_flag,
    input  logic       wr_mask,
    input  logic [1:0] wbits,
    input  logic       ev_in,
    input  logic       ev_out,
    output logic [1:0] flag_q,
    output logic [1:0] en_q,
    output logic       irq
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 2'b01;
            en_q   <= 2'b00;
        end else begin
            flag_q <= (wr_flag ? (flag_q & wbits) : flag_q) | {ev_out, ev_in};
            if (wr_mask) en_q <= wbits;
        end
    end

    assign irq = |(flag_q & en_q);
endmodule

// File: rtl/des_regfront.sv
module des_regfront
    import des_rf_pkg::*;
#(
    parameter int          AW        = 8,
    parameter int          KEY_SLOTS = 3,
    parameter int          LEN_W     = 32,
    parameter logic [2:0]  REV_MAJOR = 3'd2,
    parameter logic [5:0]  REV_MINOR = 6'd5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [AW-1:0]            bus_addr,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    output logic                     eng_start,
    output logic [63:0]              eng_din,
    output logic [64*KEY_SLOTS-1:0]  eng_key,
    output logic                     eng_tdes,
    output logic                     eng_encrypt,
    input  logic                     eng_done,
    input  logic [63:0]              eng_dout,
    output logic                     dma_in_req,
    output logic                     dma_out_req,
    output logic                     irq
);
    localparam int KEY_WORDS = 2 * KEY_SLOTS;

    logic in_rdy, out_rdy, capture, finish, consume;
    logic [31:0] din_hi_q;
    logic [63:0] raw_q, feed_q, out_q, chain_q, blk_new;
    logic cbc_q, tdes_q, enc_q;
    logic dma_in_en, dma_out_en, dma_go;
    logic [LEN_W-1:0] len_q;
    logic [1:0] flag_q, en_q;
    logic [31:0] key_word;
    logic key_hit;

    function automatic logic at(input int ofs, input logic [AW-1:0] a);
        return a == AW'(ofs);
    endfunction

    logic wr_d_hi, wr_d_lo, rd_d_lo, len_wr;
    assign wr_d_hi = bus_wr && at(OFS_D_HI, bus_addr);
    assign wr_d_lo = bus_wr && at(OFS_D_LO, bus_addr);
    assign rd_d_lo = bus_rd && at(OFS_D_LO, bus_addr);
    assign len_wr  = bus_wr && at(OFS_LEN, bus_addr);
    assign blk_new = {din_hi_q, bus_wdata};

    des_rf_keystore #(.AW(AW), .WORDS(KEY_WORDS)) keys_i (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .key_flat(eng_key), .rd_word(key_word), .rd_hit(key_hit)
    );

    des_rf_seq seq_i (
        .clk(clk), .rst_n(rst_n), .blk_wr(wr_d_lo), .blk_rd(rd_d_lo),
        .eng_done(eng_done), .in_rdy(in_rdy), .out_rdy(out_rdy),
        .eng_start(eng_start), .capture(capture), .finish(finish), .consume(consume)
    );

    des_rf_irq irq_i (
        .clk(clk), .rst_n(rst_n),
        .wr_flag(bus_wr && at(OFS_STAT, bus_addr)),
        .wr_mask(bus_wr && at(OFS_IEN, bus_addr)),
        .wbits(bus_wdata[EV_OUT_B:EV_IN_B]),
        .ev_in(consume), .ev_out(finish),
        .flag_q(flag_q), .en_q(en_q), .irq(irq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            din_hi_q <= '0;
            raw_q    <= '0;
            feed_q   <= '0;
            out_q    <= '0;
            chain_q  <= '0;
        end else begin
            if (in_rdy && wr_d_hi) din_hi_q <= bus_wdata;
            if (capture) begin
                raw_q  <= blk_new;
                feed_q <= (cbc_q && enc_q) ? (blk_new ^ chain_q) : blk_new;
            end
            if (finish)
                out_q <= (cbc_q && !enc_q) ? (eng_dout ^ chain_q) : eng_dout;
            if (finish && cbc_q)
                chain_q <= enc_q ? eng_dout : raw_q;
            else if (bus_wr && at(OFS_IV_HI, bus_addr))
                chain_q[63:32] <= bus_wdata;
            else if (bus_wr && at(OFS_IV_LO, bus_addr))
                chain_q[31:0] <= bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cbc_q <= 1'b0; tdes_q <= 1'b0; enc_q <= 1'b0;
            dma_in_en <= 1'b0; dma_out_en <= 1'b0; dma_go <= 1'b0;
            len_q <= '0;
        end else begin
            if (bus_wr && at(OFS_CTRL, bus_addr)) begin
                cbc_q  <= bus_wdata[CTRL_CBC_B];
                tdes_q <= bus_wdata[CTRL_TDES_B];
                enc_q  <= bus_wdata[CTRL_ENC_B];
            end
            if (bus_wr && at(OFS_DMA, bus_addr)) begin
                dma_in_en  <= bus_wdata[DMA_IN_B];
                dma_out_en <= bus_wdata[DMA_OUT_B];
                dma_go     <= bus_wdata[DMA_GO_B];
            end
            if (len_wr)
                len_q <= bus_wdata[LEN_W-1:0];
            else if (consume)
                len_q <= (len_q >= LEN_W'(BLK_BYTES)) ? len_q - LEN_W'(BLK_BYTES) : '0;
        end
    end

    assign eng_din     = feed_q;
    assign eng_tdes    = tdes_q;
    assign eng_encrypt = enc_q;
    assign dma_in_req  = dma_go && dma_in_en  && in_rdy  && (|len_q);
    assign dma_out_req = dma_go && dma_out_en && out_rdy && (|len_q);

    always_comb begin
        bus_rdata = '0;
        if (key_hit)                       bus_rdata = key_word;
        else if (at(OFS_IV_HI, bus_addr))  bus_rdata = chain_q[63:32];
        else if (at(OFS_IV_LO, bus_addr))  bus_rdata = chain_q[31:0];
        else if (at(OFS_CTRL, bus_addr))   bus_rdata = {27'b0, cbc_q, tdes_q, enc_q, in_rdy, out_rdy};
        else if (at(OFS_LEN, bus_addr))    bus_rdata = 32'(len_q);
        else if (at(OFS_D_HI, bus_addr))   bus_rdata = out_q[63:32];
        else if (at(OFS_D_LO, bus_addr))   bus_rdata = out_q[31:0];
        else if (at(OFS_REV, bus_addr))    bus_rdata = {21'b0, REV_MAJOR, 2'b0, REV_MINOR};
        else if (at(OFS_DMA, bus_addr))    bus_rdata = {24'b0, dma_go, dma_out_en, dma_in_en, 5'b0};
        else if (at(OFS_STAT, bus_addr))   bus_rdata = {29'b0, flag_q, 1'b0};
        else if (at(OFS_IEN, bus_addr))    bus_rdata = {29'b0, en_q, 1'b0};
    end
endmodule

// File: rtl/des_regfront_chk.sv
module des_regfront_chk #(
    parameter int LW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_rdy,
    input logic          out_rdy,
    input logic          eng_start,
    input logic          dma_in_req,
    input logic          dma_out_req,
    input logic [LW-1:0] len_q,
    input logic          len_wr,
    input logic [1:0]    flag_q
);
    // R4
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);
    // R4
    start_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> $past(in_rdy));
    // R5
    ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_rdy && out_rdy));
    // R12
    dma_len_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (len_q == '0) |-> (!dma_in_req && !dma_out_req));
    // R9
    data_out_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_rdy) |-> flag_q[1]);
    // R9
    data_in_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_rdy) |-> flag_q[0]);
    // R11
    len_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(out_rdy) && !$past(len_wr) && ($past(len_q) >= LW'(8)))
            |-> (len_q == $past(len_q) - LW'(8)));
endmodule

bind des_regfront des_regfront_chk #(.LW(LEN_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_rdy(in_rdy), .out_rdy(out_rdy),
    .eng_start(eng_start), .dma_in_req(dma_in_req), .dma_out_req(dma_out_req),
    .len_q(len_q), .len_wr(len_wr), .flag_q(flag_q)
);

// File: tb/des_regfront_tb_top.sv
`timescale 1ns/100ps
module des_regfront_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic eng_start, eng_tdes, eng_encrypt;
    logic [63:0] eng_din;
    logic [191:0] eng_key;
    logic eng_done;
    logic [63:0] eng_dout;
    logic dma_in_req, dma_out_req, irq;

    int n_chk = 0, n_err = 0;

    always #2.5 clk = ~clk;

    des_regfront dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_start(eng_start), .eng_din(eng_din), .eng_key(eng_key),
        .eng_tdes(eng_tdes), .eng_encrypt(eng_encrypt), .eng_done(eng_done),
        .eng_dout(eng_dout), .dma_in_req(dma_in_req), .dma_out_req(dma_out_req),
        .irq(irq)
    );

    // stand-in cipher engine: keyed, encrypt and decrypt are inverses
    function automatic logic [63:0] stub_f(input logic [63:0] x, input logic [191:0] k,
                                           input logic tdes, input logic enc);
        logic [63:0] kk;
        kk = tdes ? (k[191:128] ^ k[127:64] ^ k[63:0]) : k[191:128];
        return enc ? ((x ^ kk) + 64'd1) : ((x - 64'd1) ^ kk);
    endfunction

    logic [63:0] stub_hold;
    int stub_cnt;
    always @(posedge clk) begin
        eng_done <= 1'b0;
        if (!rst_n) begin
            stub_cnt <= 0;
            eng_dout <= '0;
        end else if (eng_start) begin
            stub_hold <= stub_f(eng_din, eng_key, eng_tdes, eng_encrypt);
            stub_cnt  <= 3;
        end else if (stub_cnt != 0) begin
            stub_cnt <= stub_cnt - 1;
            if (stub_cnt == 1) begin
                eng_done <= 1'b1;
                eng_dout <= stub_hold;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    // scoreboard
    logic [63:0] exp_q[$];
    string       tag_q[$];
    logic [63:0] got_blk;
    event        blk_seen;
    logic [31:0] key_w [6] = '{32'h01234567, 32'h89ABCDEF, 32'hFEDCBA98,
                               32'h76543210, 32'h0F1E2D3C, 32'h4B5A6978};
    logic [191:0] key_v;
    logic [63:0]  b_chain;

    always @(blk_seen) begin
        if (exp_q.size() == 0) chk(1'b0, "R5 unexpected block", got_blk, '0);
        else begin
            automatic logic [63:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            chk(got_blk == e, t, got_blk, e);
        end
    end

    task automatic push_block(input logic [63:0] p, input bit cbc, input bit enc,
                              input bit tdes, input string tag);
        logic [63:0] e;
        bus_write(8'h20, 32'({cbc, tdes, enc, 2'b00}));
        if (cbc && enc) begin
            e = stub_f(p ^ b_chain, key_v, tdes, 1'b1); b_chain = e;
        end else if (cbc) begin
            e = stub_f(p, key_v, tdes, 1'b0) ^ b_chain; b_chain = p;
        end else e = stub_f(p, key_v, tdes, enc);
        exp_q.push_back(e); tag_q.push_back(tag);
        bus_write(8'h28, p[63:32]);
        bus_write(8'h2C, p[31:0]);
    endtask

    task automatic wait_out();
        logic [31:0] v = '0;
        for (int i = 0; i < 40 && !v[0]; i++) bus_read(8'h20, v);
        chk(v[0], "R5 output-ready", 64'(v), 64'h1);
    endtask

    task automatic pull_block();
        logic [31:0] hi, lo;
        wait_out();
        bus_read(8'h28, hi);
        bus_read(8'h2C, lo);
        got_blk = {hi, lo};
        ->blk_seen;
        #1;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", '0, '0);
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [63:0] c0, c1, iv0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        bus_read(8'h20, v); chk(v == 32'h2, "R1 ctrl", 64'(v), 64'h2);
        bus_read(8'h3C, v); chk(v == 32'h2, "R1 status", 64'(v), 64'h2);
        bus_read(8'h40, v); chk(v == 32'h0, "R1 enable", 64'(v), 64'h0);
        bus_read(8'h24, v); chk(v == 32'h0, "R1 length", 64'(v), 64'h0);
        bus_read(8'h34, v); chk(v == 32'h0, "R1 dma mask", 64'(v), 64'h0);
        chk({irq, dma_in_req, dma_out_req} == 3'b0, "R1 outputs",
            64'({irq, dma_in_req, dma_out_req}), 64'h0);

        // R13 revision
        bus_read(8'h30, v); chk(v == 32'h0000_0205, "R13 revision", 64'(v), 64'h205);

        // R2 key layout
        for (int k = 0; k < 6; k++) bus_write(8'(20 - 4 * (k ^ 1)), key_w[k]);
        key_v = {key_w[0], key_w[1], key_w[2], key_w[3], key_w[4], key_w[5]};
        bus_read(8'h10, v); chk(v == key_w[0], "R2 word0 at 0x10", 64'(v), 64'(key_w[0]));
        bus_read(8'h0C, v); chk(v == key_w[3], "R2 word3 at 0x0C", 64'(v), 64'(key_w[3]));
        bus_read(8'h00, v); chk(v == key_w[4], "R2 word4 at 0x00", 64'(v), 64'(key_w[4]));
        chk(eng_key == key_v, "R2 key port", eng_key[63:0], key_v[63:0]);

        // R9 / R10 status and interrupt
        bus_write(8'h40, 32'h2);
        #1 chk(irq == 1'b1, "R10 irq data-in", 64'(irq), 64'h1);
        bus_write(8'h3C, 32'hFFFF_FFFF);
        bus_read(8'h3C, v); chk(v == 32'h2, "R9 write one no effect", 64'(v), 64'h2);
        bus_write(8'h3C, 32'h0);
        bus_read(8'h3C, v); chk(v == 32'h0, "R9 write zero clears", 64'(v), 64'h0);
        chk(irq == 1'b0, "R10 irq low", 64'(irq), 64'h0);

        // R3 control bits
        bus_write(8'h20, 32'h1F);
        bus_read(8'h20, v); chk(v == 32'h1E, "R3 ctrl readback", 64'(v), 64'h1E);
        chk({eng_tdes, eng_encrypt} == 2'b11, "R3 engine flags",
            64'({eng_tdes, eng_encrypt}), 64'h3);

        // R4 ECB single key, both directions; interrupt ping-pong
        bus_write(8'h40, 32'h4);
        push_block(64'h0011_2233_4455_6677, 1'b0, 1'b1, 1'b0, "R4 ECB encrypt");
        wait_out();
        bus_read(8'h3C, v); chk(v == 32'h4, "R9 data-out set", 64'(v), 64'h4);
        chk(irq == 1'b1, "R10 irq data-out", 64'(irq), 64'h1);
        pull_block();
        bus_read(8'h3C, v); chk(v == 32'h6, "R9 data-in set", 64'(v), 64'h6);
        push_block(64'h8899_AABB_CCDD_EEFF, 1'b0, 1'b0, 1'b0, "R4 ECB decrypt");
        pull_block();

        // R3 Triple-DES uses all slots
        push_block(64'hDEAD_BEEF_0BAD_F00D, 1'b0, 1'b1, 1'b1, "R3 TDES encrypt");
        pull_block();

        // R5 partial read and R6 writes while not ready
        push_block(64'h1357_9BDF_2468_ACE0, 1'b0, 1'b1, 1'b0, "R6 result kept");
        wait_out();
        bus_read(8'h28, v);
        bus_read(8'h20, v); chk(v[1:0] == 2'b01, "R5 high read keeps ready", 64'(v[1:0]), 64'h1);
        bus_write(8'h28, 32'hAAAA_AAAA);
        bus_write(8'h2C, 32'h5555_5555);
        bus_read(8'h20, v); chk(v[1:0] == 2'b01, "R6 ready unchanged", 64'(v[1:0]), 64'h1);
        pull_block();

        // R7 CBC encrypt, two blocks
        iv0 = 64'hCAFE_F00D_1234_5678;
        bus_write(8'h18, iv0[63:32]); bus_write(8'h1C, iv0[31:0]);
        b_chain = iv0;
        push_block(64'h0102_0304_0506_0708, 1'b1, 1'b1, 1'b0, "R7 CBC encrypt 1");
        pull_block(); c0 = b_chain;
        push_block(64'h1112_1314_1516_1718, 1'b1, 1'b1, 1'b0, "R7 CBC encrypt 2");
        pull_block(); c1 = b_chain;
        bus_read(8'h18, v); chk(v == c1[63:32], "R7 IV high", 64'(v), 64'(c1[63:32]));
        bus_read(8'h1C, v); chk(v == c1[31:0], "R7 IV low", 64'(v), 64'(c1[31:0]));

        // R8 CBC decrypt of the same ciphertexts
        bus_write(8'h18, iv0[63:32]); bus_write(8'h1C, iv0[31:0]);
        b_chain = iv0;
        push_block(c0, 1'b1, 1'b0, 1'b0, "R8 CBC decrypt 1");
        pull_block();
        push_block(c1, 1'b1, 1'b0, 1'b0, "R8 CBC decrypt 2");
        pull_block();
        chk(b_chain == c1, "R8 chain follows ciphertext", b_chain, c1);

        // R11 length countdown
        bus_write(8'h24, 32'd24);
        for (int b = 0; b < 4; b++) begin
            automatic logic [31:0] want = (b < 3) ? 32'(16 - 8 * b) : 32'd0;
            push_block(64'(b) * 64'h0101_0101_0101_0101, 1'b0, 1'b1, 1'b0, "R11 block");
            pull_block();
            bus_read(8'h24, v); chk(v == want, "R11 length", 64'(v), 64'(want));
        end

        // R12 DMA requests
        bus_write(8'h24, 32'd8);
        bus_write(8'h34, 32'hE0);
        #1 chk({dma_in_req, dma_out_req} == 2'b10, "R12 input request",
               64'({dma_in_req, dma_out_req}), 64'h2);
        push_block(64'h7777_0000_7777_0000, 1'b0, 1'b1, 1'b0, "R12 DMA block");
        wait_out();
        chk({dma_in_req, dma_out_req} == 2'b01, "R12 output request",
            64'({dma_in_req, dma_out_req}), 64'h1);
        pull_block();
        chk({dma_in_req, dma_out_req} == 2'b00, "R12 drop at zero",
            64'({dma_in_req, dma_out_req}), 64'h0);

        repeat (4) @(posedge clk);
        chk(exp_q.size() == 0, "R5 all results seen", 64'(exp_q.size()), 64'h0);
        summary();
        $finish;
    end
endmodule